// File: doc/BRIEF.md
# NRZI Bit-Stuffing Line Codec

This block is the bit-level line coder for a full-speed serial bus. On the transmit side it takes packet bits one per bit-time through a valid/ready handshake. When a run of ones reaches six, it inserts a zero that carries no data. It then codes the stream so that a zero flips the line and a one leaves it unchanged. Each packet closes with an end-of-packet condition: both wires low for two bit-times, then one bit-time of the idle state, after which the wires are released. Every packet is coded starting from the idle state J. Each clock cycle is one bit-time.

The receive side samples the wire pair once per bit-time. A packet starts at the first K state after idle. The receiver decodes the levels back into bits, drops each inserted zero, reports the end of a packet, and flags a stuffing violation when a seventh one arrives where an inserted zero was due. With the two sides looped together, each packet's bits come back out of the receiver exactly as they went in.

Top module: `nrziStuffCodec`

## Requirements
- R1: Line states are J = (txDp=1, txDn=0) and K = (txDp=0, txDn=1). A data bit of 0 flips the line and a 1 holds it. The first bit of a packet is coded against J. A bit accepted at a clock edge appears on the line from that edge until the next.
- R2: When six ones in a row have been sent, counted from packet start, a zero is inserted before the next bit. Any zero, inserted or not, clears the count, so a driven data level never lasts more than seven bit-times.
- R3: While an inserted zero is on its way out, txReady is low for exactly one cycle and no data bit is accepted.
- R4: If the final bit of a packet completes a run of six ones, the inserted zero is still sent before the end-of-packet.
- R5: After the last bit is sent, the line shows SE0 (both wires low) for exactly two bit-times, then J for one bit-time with txOe high, and then txOe falls. txReady stays low from the cycle after the last bit is accepted until txOe falls.
- R6: When idle, txOe is low, the wires rest at J and txReady is high.
- R7: If txValid is low when a bit is due inside a packet, the encoder ends the packet at once with the normal end-of-packet sequence.
- R8: The receiver delivers each data bit with a one-cycle rxValid, in transmit order, and drops every inserted zero.
- R9: If a one arrives where an inserted zero was due, the receiver pulses rxStuffErr once. It then ignores the rest of that packet (no rxValid, no rxEop) until it has seen SE0 followed by J.
- R10: Two consecutive SE0 bit-times inside a packet produce a single rxEop pulse.
- R11: The receiver ignores J and SE0 while idle. A packet starts at the first K, and that bit is decoded as 0.
- R12: During and right after reset, rxValid, rxEop and rxStuffErr are low, and the transmitter is in its idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rstN | input | 1 | Active-low reset |
| txValid | input | 1 | A packet bit is offered |
| txData | input | 1 | Offered packet bit |
| txLast | input | 1 | Offered bit is the final bit of the packet |
| txReady | output | 1 | Encoder takes the offered bit at this edge |
| txDp | output | 1 | Positive wire level |
| txDn | output | 1 | Negative wire level |
| txOe | output | 1 | Wire pair is being driven |
| rxDp | input | 1 | Sampled positive wire |
| rxDn | input | 1 | Sampled negative wire |
| rxValid | output | 1 | Decoded data bit available |
| rxData | output | 1 | Decoded data bit |
| rxEop | output | 1 | End of packet seen |
| rxStuffErr | output | 1 | Stuffing violation seen |

## Verification
Some properties are checked on every cycle: the driven data level never lasts longer than the stuffing rule allows, SE0 lasts exactly two bit-times and is followed by one J and then release, txReady stays low during SE0, the idle wires sit at J, and the receiver raises at most one of its strobes at a time. Other behaviour needs whole packets and is shown only by the bench scenarios. This covers the exact coded wire sequence for a range of packets, including stuffing after the final bit and a one-bit packet. It also covers the count of stall cycles, the bits that come back through the receiver, the early close on underrun, and the receiver dropping a packet after a stuffing violation and then recovering.

// File: rtl/nrziCodecPkg.sv
package nrziCodecPkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_DATA,
    TX_STUFF,
    TX_SE0A,
    TX_SE0B,
    TX_JEND
  } txState_e;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ACT,
    RX_SE0,
    RX_WAITJ,
    RX_ERR
  } rxState_e;

  // strobes from transmit control to transmit datapath
  typedef struct packed {
    logic loadBit;      // take txData into the coder
    logic stuffBit;     // emit an inserted zero
    logic lineRestart;  // return level to J, clear run count
    logic driveSe0;     // both wires low
    logic driveOe;      // wires driven
  } txStrobe_t;

endpackage

// File: rtl/nrziTxCtrl.sv
module nrziTxCtrl
  import nrziCodecPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txValid,
  input  logic      txLast,
  input  logic      runFull,
  output logic      txReady,
  output txStrobe_t strobe
);

  txState_e state, nextState;
  logic     lastSeen;
  logic     inData;
  logic     canTake;
  logic     accept;

  always_comb begin
    inData  = (state == TX_DATA) || (state == TX_STUFF);
    canTake = inData && !runFull && !lastSeen;
    txReady = (state == TX_IDLE) || canTake;
    accept  = txValid && txReady;
  end

  always_comb begin
    nextState = state;
    case (state)
      TX_IDLE:  if (txValid) nextState = TX_DATA;
      TX_DATA, TX_STUFF: begin
        if (runFull)                    nextState = TX_STUFF;
        else if (lastSeen || !txValid)  nextState = TX_SE0A;
        else                            nextState = TX_DATA;
      end
      TX_SE0A:  nextState = TX_SE0B;
      TX_SE0B:  nextState = TX_JEND;
      TX_JEND:  nextState = TX_IDLE;
      default:  nextState = TX_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadBit     = accept;
    strobe.stuffBit    = inData && runFull;
    strobe.lineRestart = (state == TX_SE0B);
    strobe.driveSe0    = (state == TX_SE0A) || (state == TX_SE0B);
    strobe.driveOe     = (state != TX_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= TX_IDLE;
      lastSeen <= 1'b0;
    end else begin
      state <= nextState;
      if (state == TX_SE0B)        lastSeen <= 1'b0;
      else if (accept && txLast)   lastSeen <= 1'b1;
    end
  end

endmodule

// File: rtl/nrziTxPath.sv
module nrziTxPath
  import nrziCodecPkg::*;
#(
  parameter int RUN_LIMIT = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  txStrobe_t strobe,
  input  logic      txData,
  output logic      runFull,
  output logic      txDp,
  output logic      txDn,
  output logic      txOe
);

  localparam int CW = $clog2(RUN_LIMIT + 1);

  logic          lineLevel;   // 1 = J, 0 = K
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineLevel <= 1'b1;
      runCnt    <= '0;
    end else if (strobe.lineRestart) begin
      lineLevel <= 1'b1;
      runCnt    <= '0;
    end else if (strobe.stuffBit) begin
      lineLevel <= ~lineLevel;
      runCnt    <= '0;
    end else if (strobe.loadBit) begin
      if (txData) begin
        runCnt <= runCnt + CW'(1);
      end else begin
        lineLevel <= ~lineLevel;
        runCnt    <= '0;
      end
    end
  end

  always_comb begin
    runFull = (runCnt == CW'(RUN_LIMIT));
    txOe    = strobe.driveOe;
    txDp    = !strobe.driveSe0 && lineLevel;
    txDn    = !strobe.driveSe0 && !lineLevel;
  end

endmodule

// File: rtl/nrziRxUnstuff.sv
module nrziRxUnstuff
  import nrziCodecPkg::*;
#(
  parameter int RUN_LIMIT = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxDp,
  input  logic rxDn,
  output logic rxValid,
  output logic rxData,
  output logic rxEop,
  output logic rxStuffErr
);

  localparam int CW = $clog2(RUN_LIMIT + 1);

  rxState_e      state, nState;
  logic          prevJ, nPrevJ;
  logic [CW-1:0] ones, nOnes;
  logic          isSe0, isK, levelJ, bitVal;
  logic          vOut, dOut, eOut, errOut;

  always_comb begin
    isSe0  = !rxDp && !rxDn;
    isK    = !rxDp && rxDn;
    levelJ = !isK;
  end

  always_comb begin
    nState = state;
    nPrevJ = prevJ;
    nOnes  = ones;
    vOut   = 1'b0;
    dOut   = 1'b0;
    eOut   = 1'b0;
    errOut = 1'b0;
    bitVal = (levelJ == prevJ);
    case (state)
      RX_IDLE: begin
        if (isK) begin
          nState = RX_ACT;
          nPrevJ = 1'b0;
          nOnes  = '0;
          vOut   = 1'b1;
        end
      end
      RX_ACT: begin
        if (isSe0) begin
          nState = RX_SE0;
        end else begin
          nPrevJ = levelJ;
          if (ones == CW'(RUN_LIMIT)) begin
            if (bitVal) begin
              errOut = 1'b1;
              nState = RX_ERR;
            end else begin
              nOnes = '0;
            end
          end else begin
            vOut  = 1'b1;
            dOut  = bitVal;
            nOnes = bitVal ? ones + CW'(1) : '0;
          end
        end
      end
      RX_SE0: begin
        eOut   = isSe0;
        nState = RX_WAITJ;
      end
      RX_WAITJ: if (!isSe0 && levelJ) nState = RX_IDLE;
      RX_ERR:   if (isSe0) nState = RX_WAITJ;
      default:  nState = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= RX_IDLE;
      prevJ      <= 1'b1;
      ones       <= '0;
      rxValid    <= 1'b0;
      rxData     <= 1'b0;
      rxEop      <= 1'b0;
      rxStuffErr <= 1'b0;
    end else begin
      state      <= nState;
      prevJ      <= nPrevJ;
      ones       <= nOnes;
      rxValid    <= vOut;
      rxData     <= dOut;
      rxEop      <= eOut;
      rxStuffErr <= errOut;
    end
  end

endmodule

// File: rtl/nrziStuffCodec.sv
module nrziStuffCodec
  import nrziCodecPkg::*;
#(
  parameter int RUN_LIMIT = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic txValid,
  input  logic txData,
  input  logic txLast,
  output logic txReady,
  output logic txDp,
  output logic txDn,
  output logic txOe,
  input  logic rxDp,
  input  logic rxDn,
  output logic rxValid,
  output logic rxData,
  output logic rxEop,
  output logic rxStuffErr
);

  txStrobe_t txStrobe;
  logic      runFull;

  nrziTxCtrl uTxCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .txValid (txValid),
    .txLast  (txLast),
    .runFull (runFull),
    .txReady (txReady),
    .strobe  (txStrobe)
  );

  nrziTxPath #(.RUN_LIMIT(RUN_LIMIT)) uTxPath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (txStrobe),
    .txData  (txData),
    .runFull (runFull),
    .txDp    (txDp),
    .txDn    (txDn),
    .txOe    (txOe)
  );

  nrziRxUnstuff #(.RUN_LIMIT(RUN_LIMIT)) uRx (
    .clk        (clk),
    .rstN       (rstN),
    .rxDp       (rxDp),
    .rxDn       (rxDn),
    .rxValid    (rxValid),
    .rxData     (rxData),
    .rxEop      (rxEop),
    .rxStuffErr (rxStuffErr)
  );

endmodule

// File: rtl/nrziStuffCodecChk.sv
module nrziStuffCodecChk #(
  parameter int RUN_LIMIT = 6
) (
  input logic clk,
  input logic rstN,
  input logic txReady,
  input logic txDp,
  input logic txDn,
  input logic txOe,
  input logic rxValid,
  input logic rxEop,
  input logic rxStuffErr
);

  localparam int SW = $clog2(RUN_LIMIT + 3);

  logic          se0;
  logic          drv;
  logic          prevDrv;
  logic          prevSym;
  logic [SW-1:0] sameCnt;

  always_comb begin
    se0 = txOe && !txDp && !txDn;
    drv = txOe && !se0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevDrv <= 1'b0;
      prevSym <= 1'b0;
      sameCnt <= '0;
    end else begin
      prevDrv <= drv;
      prevSym <= txDp;
      if (!drv)                          sameCnt <= '0;
      else if (prevDrv && txDp == prevSym) sameCnt <= sameCnt + SW'(1);
      else                               sameCnt <= SW'(1);
    end
  end

  // R2
  run_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    sameCnt <= SW'(RUN_LIMIT + 1));

  // R6
  idle_j_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txOe |-> (txDp && !txDn && txReady));

  // R5
  se0_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(se0) |=> se0);

  // R5
  se0_then_j_chk: assert property (@(posedge clk) disable iff (!rstN)
    (se0 && $past(se0)) |=> (txOe && txDp && !txDn));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txOe && !se0 && $past(se0)) |=> !txOe);

  // R5
  eop_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    se0 |-> !txReady);

  // R9
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxValid, rxEop, rxStuffErr}));

endmodule

bind nrziStuffCodec nrziStuffCodecChk #(.RUN_LIMIT(RUN_LIMIT)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .txReady    (txReady),
  .txDp       (txDp),
  .txDn       (txDn),
  .txOe       (txOe),
  .rxValid    (rxValid),
  .rxEop      (rxEop),
  .rxStuffErr (rxStuffErr)
);

// File: tb/tb_nrziStuffCodec.sv
module tb_nrziStuffCodec;

  localparam int RUNMAX = 6;
  localparam int NV     = 8;
  // {bits[15:0], length, inserted zeros, stall cycles}
  localparam logic [39:0] VEC [NV] = '{
    {16'h0000, 8'd8,  8'd0, 8'd0},
    {16'h00FE, 8'd8,  8'd1, 8'd1},
    {16'hFFFE, 8'd16, 8'd2, 8'd2},
    {16'h007E, 8'd7,  8'd1, 8'd0},
    {16'h003E, 8'd6,  8'd0, 8'd0},
    {16'hAAAA, 8'd16, 8'd0, 8'd0},
    {16'hDF7E, 8'd16, 8'd1, 8'd1},
    {16'h0000, 8'd1,  8'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txValid = 1'b0, txData = 1'b0, txLast = 1'b0;
  logic txReady, txDp, txDn, txOe;
  logic rxDp, rxDn;
  logic rxValid, rxData, rxEop, rxStuffErr;
  logic useInject = 1'b0, injDp = 1'b1, injDn = 1'b0;

  int total = 0;
  int fails = 0;

  logic [1:0] capSym [64];
  logic       capBit [64];
  logic [1:0] refSym [64];
  int symCnt = 0, rxCnt = 0, eopCnt = 0, errCnt = 0, refCnt = 0;

  always #5 clk = ~clk;

  assign rxDp = useInject ? injDp : (txOe ? txDp : 1'b1);
  assign rxDn = useInject ? injDn : (txOe ? txDn : 1'b0);

  nrziStuffCodec dut (
    .clk(clk), .rstN(rstN),
    .txValid(txValid), .txData(txData), .txLast(txLast), .txReady(txReady),
    .txDp(txDp), .txDn(txDn), .txOe(txOe),
    .rxDp(rxDp), .rxDn(rxDn),
    .rxValid(rxValid), .rxData(rxData), .rxEop(rxEop), .rxStuffErr(rxStuffErr)
  );

  // capture after each edge settles
  always begin
    @(posedge clk);
    #1;
    if (txOe && symCnt < 64) begin
      capSym[symCnt] = {txDp, txDn};
      symCnt++;
    end
    if (rxValid && rxCnt < 64) begin
      capBit[rxCnt] = rxData;
      rxCnt++;
    end
    if (rxEop) eopCnt++;
    if (rxStuffErr) errCnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearCap();
    @(negedge clk);
    symCnt = 0; rxCnt = 0; eopCnt = 0; errCnt = 0;
  endtask

  // expected wire sequence from the coding rules
  task automatic buildRef(input logic [15:0] bits, input int len);
    logic lvl = 1'b1;
    int run = 0;
    refCnt = 0;
    for (int i = 0; i < len; i++) begin
      if (!bits[i]) lvl = ~lvl;
      refSym[refCnt] = lvl ? 2'b10 : 2'b01; refCnt++;
      run = bits[i] ? run + 1 : 0;
      if (run == RUNMAX) begin
        lvl = ~lvl;
        refSym[refCnt] = lvl ? 2'b10 : 2'b01; refCnt++;
        run = 0;
      end
    end
    refSym[refCnt] = 2'b00; refCnt++;
    refSym[refCnt] = 2'b00; refCnt++;
    refSym[refCnt] = 2'b10; refCnt++;
  endtask

  task automatic sendBits(input logic [15:0] bits, input int len,
                          input bit withLast, output int stalls);
    int i = 0;
    stalls = 0;
    while (i < len) begin
      @(negedge clk);
      txValid = 1'b1;
      txData  = bits[i];
      txLast  = withLast && (i == len - 1);
      #1;
      if (txReady) i++;
      else stalls++;
    end
    @(negedge clk);
    txValid = 1'b0;
    txLast  = 1'b0;
    txData  = 1'b0;
  endtask

  task automatic compareLine(input string req);
    int bad = 0;
    int firstBad = -1;
    for (int k = 0; k < symCnt && k < refCnt; k++) begin
      if (capSym[k] !== refSym[k]) begin
        bad++;
        if (firstBad < 0) firstBad = k;
      end
    end
    chk(bad == 0, req, "wire symbol mismatches (first index in actual)",
        firstBad, -1);
  endtask

  task automatic compareRx(input logic [15:0] bits, input int len, input string req);
    int bad = 0;
    chk(rxCnt == len, req, "decoded bit count", rxCnt, len);
    for (int k = 0; k < rxCnt && k < len; k++)
      if (capBit[k] !== bits[k]) bad++;
    chk(bad == 0, req, "decoded bit mismatches", bad, 0);
  endtask

  task automatic injectSym(input logic [1:0] s);
    @(negedge clk);
    injDp = s[1];
    injDn = s[0];
  endtask

  initial begin
    #1500000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int stalls;
    int oeCycles;
    int readyHigh;

    // R12 R6: reset state
    repeat (3) @(negedge clk);
    chk(txOe == 1'b0 && txDp == 1'b1 && txDn == 1'b0, "R6", "idle wires during reset",
        {txOe, txDp, txDn}, 3'b010);
    chk(rxValid == 1'b0 && rxEop == 1'b0 && rxStuffErr == 1'b0, "R12",
        "rx strobes during reset", {rxValid, rxEop, rxStuffErr}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(txReady == 1'b1 && txOe == 1'b0, "R6", "ready and released after reset",
        {txReady, txOe}, 2'b10);
    chk(rxValid == 1'b0 && rxEop == 1'b0, "R12", "rx quiet after reset",
        {rxValid, rxEop}, 0);

    // table of packets through the loopback
    for (int v = 0; v < NV; v++) begin
      logic [15:0] bits;
      int len, expStuff, expStall;
      bits     = VEC[v][39:24];
      len      = int'(VEC[v][23:16]);
      expStuff = int'(VEC[v][15:8]);
      expStall = int'(VEC[v][7:0]);
      clearCap();
      buildRef(bits, len);
      sendBits(bits, len, 1'b1, stalls);
      repeat (8) @(negedge clk);
      // R2 R4: length includes inserted zeros, R5: plus three end symbols
      chk(symCnt == len + expStuff + 3, "R2/R4", "driven bit-times", symCnt,
          len + expStuff + 3);
      compareLine("R1/R5");
      // R3: one stall per inserted zero before the last bit
      chk(stalls == expStall, "R3", "stall cycles", stalls, expStall);
      compareRx(bits, len, "R8/R11");
      chk(eopCnt == 1 && errCnt == 0, "R10", "eop and error pulses",
          eopCnt * 10 + errCnt, 10);
      #1;
      chk(txOe == 1'b0 && txReady == 1'b1, "R6", "idle after packet",
          {txOe, txReady}, 2'b01);
    end

    // R5: ready held low until release
    clearCap();
    sendBits(16'h0002, 2, 1'b1, stalls);
    oeCycles = 0;
    readyHigh = 0;
    #1;
    while (txOe && oeCycles < 20) begin
      oeCycles++;
      if (txReady) readyHigh++;
      @(negedge clk);
      #1;
    end
    chk(oeCycles == 4, "R5", "driven cycles after last accept", oeCycles, 4);
    chk(readyHigh == 0, "R5", "ready high while closing", readyHigh, 0);
    repeat (4) @(negedge clk);

    // R7: underrun closes the packet early
    clearCap();
    buildRef(16'h0002, 3);
    sendBits(16'h0002, 3, 1'b0, stalls);
    repeat (8) @(negedge clk);
    chk(symCnt == 6, "R7", "driven bit-times on underrun", symCnt, 6);
    compareLine("R7");
    chk(eopCnt == 1, "R7", "eop after underrun", eopCnt, 1);

    // R9 R11: stuffing violation on the receive wires
    clearCap();
    useInject = 1'b1;
    injectSym(2'b10);
    injectSym(2'b00);
    injectSym(2'b10);
    for (int k = 0; k < 8; k++) injectSym(2'b01);
    injectSym(2'b10);
    injectSym(2'b01);
    injectSym(2'b00);
    injectSym(2'b00);
    injectSym(2'b10);
    injectSym(2'b10);
    repeat (3) @(negedge clk);
    chk(errCnt == 1, "R9", "stuff error pulses", errCnt, 1);
    chk(rxCnt == 7, "R9/R11", "bits before the violation", rxCnt, 7);
    chk(rxCnt >= 7 && capBit[0] == 1'b0 && capBit[6] == 1'b1, "R11",
        "first bit zero, last one", rxCnt, 7);
    chk(eopCnt == 0, "R9", "eop after violation", eopCnt, 0);

    // R9: receiver recovers for the next packet
    useInject = 1'b0;
    clearCap();
    sendBits(16'h000A, 4, 1'b1, stalls);
    repeat (8) @(negedge clk);
    compareRx(16'h000A, 4, "R9");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule